// File: doc/BRIEF.md
# Flash Readout Protection Controller

This block guards an on-chip flash against being read out through a debugger. A 16-bit protection word, presented at start-up and captured on a load strobe, is decoded into one of three protection levels. Level 0 restricts nothing. Level 2 shuts the debugger out of flash entirely and cannot be lowered. Level 1 lets the debugger stay connected, but the lock closes permanently the first time the debugger touches the system bus. From then on, every flash read from the CPU fetch port, the DMA port and the debug port gets an error response instead of data.

Three read ports share the flash through a fixed-priority arbiter: CPU first, then DMA, then debug. Each granted read gets its response one cycle later. The lock closes in the same cycle as the debug grant that arms it, so no debug read can reach flash data, whatever the CPU traffic around it.

Level changes go through a small controller. Raising the level is accepted at once. Lowering from 1 to 0 raises an erase request and keeps level 1 and the lock until the erase completes. Lowering from level 2 is refused.

Top module: `flash_rdp_ctrl`

## Requirements
- R1: Protection word layout is level byte in bits [7:0] and its check byte in bits [15:8]. 0x55AA decodes to level 0, 0x33CC decodes to level 2, and every other value decodes to level 1, including a pair whose bytes are not complements. Before any load, and after power-on reset, the level is 1.
- R2: In the cycle of a request, a grant is given to exactly one requester, in the order CPU, DMA, debug. Debug is granted only in a cycle with no CPU or DMA request.
- R3: One cycle after a grant, the granted port sees rvalid if the read was allowed or err if it was blocked. flash_rd_o pulses only in the grant cycle of an allowed read. rdata_o equals flash_rdata_i while any rvalid is high and is zero otherwise.
- R4: At level 1, a debug system-bus access (dbg_acc_i with dbg_sys_i=1) or a debug read grant raises lock_o in that same cycle. While lock_o is high at level 1, reads from all three ports are blocked, including the arming debug read.
- R5: A debug access with dbg_sys_i=0, which targets a debug-port internal register, never raises lock_o.
- R6: At level 0, no read is blocked and debug activity never raises lock_o.
- R7: At level 2, every debug read is answered with err, CPU and DMA reads are allowed, and debug accesses do not raise lock_o.
- R8: Once set, lock_o stays high through warm_rst_i and is cleared only by rst_ni or a completed level-0 erase. warm_rst_i drops in-flight responses and cancels a pending erase, and it leaves the level unchanged.
- R9: A change request (chg_tgt_i encodes the level, 3 is invalid) to a higher level or to the current level pulses chg_ack_o in the next cycle. For a higher level, level_o updates in that same next cycle.
- R10: A request for level 0 made at level 1 raises erase_req_o from the next cycle. Level 1 and the lock are held until erase_done_i, and then level 0 is reported, the lock is cleared and chg_ack_o pulses in the next cycle.
- R11: A request to lower level 2, a request with target 3, and any request made while an erase is pending each pulse chg_rej_o in the next cycle and leave the level unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Power-on reset, active low, asynchronous |
| warm_rst_i | input | 1 | Warm reset; does not clear the lock |
| opt_load_i | input | 1 | Capture opt_word_i as the protection word |
| opt_word_i | input | 16 | Protection word: level byte [7:0], check byte [15:8] |
| cpu_req_i | input | 1 | CPU fetch read request |
| cpu_gnt_o | output | 1 | CPU grant |
| cpu_rvalid_o | output | 1 | CPU read data valid |
| cpu_err_o | output | 1 | CPU bus error |
| dma_req_i | input | 1 | DMA read request |
| dma_gnt_o | output | 1 | DMA grant |
| dma_rvalid_o | output | 1 | DMA read data valid |
| dma_err_o | output | 1 | DMA bus error |
| dbg_req_i | input | 1 | Debug flash read request |
| dbg_gnt_o | output | 1 | Debug grant (address phase) |
| dbg_rvalid_o | output | 1 | Debug read data valid |
| dbg_err_o | output | 1 | Debug bus error |
| dbg_acc_i | input | 1 | Debugger transaction other than a flash read |
| dbg_sys_i | input | 1 | 1: that transaction targets the system bus; 0: internal register |
| flash_rd_o | output | 1 | Read strobe to the flash array |
| flash_rdata_i | input | 32 | Flash array read data |
| rdata_o | output | 32 | Read data to the ports |
| chg_req_i | input | 1 | Level change request |
| chg_tgt_i | input | 2 | Target level |
| chg_ack_o | output | 1 | Change accepted and completed |
| chg_rej_o | output | 1 | Change refused |
| erase_req_o | output | 1 | Full erase request |
| erase_done_i | input | 1 | Full erase completed |
| level_o | output | 2 | Current protection level |
| lock_o | output | 1 | Flash read lock |

## Verification
The hardest case is a debug read that finally wins arbitration after several cycles of being held off by CPU traffic at level 1. The lock must close in that exact grant cycle, and the read must come back as an error, not data. The bench holds a CPU request alongside a pending debug read and checks that lock_o stays low while debug is not granted. It then drops the CPU request and checks lock_o, flash_rd_o and the next-cycle response against a behavioural model on every clock. Random request mixes at levels 0 and 1, warm resets over a set lock, and an erase window that is interrupted by further change requests cover the rest.

// File: rtl/rdp_pkg.sv
package rdp_pkg;
  localparam int N_SRC   = 3;
  localparam int SRC_CPU = 0;
  localparam int SRC_DMA = 1;
  localparam int SRC_DBG = 2;

  typedef enum logic [1:0] {
    LVL_OPEN  = 2'd0,
    LVL_GUARD = 2'd1,
    LVL_SEAL  = 2'd2
  } rdp_lvl_e;

  localparam logic [7:0] OPEN_KEY  = 8'hAA;
  localparam logic [7:0] SEAL_KEY  = 8'hCC;
  localparam logic [7:0] GUARD_KEY = 8'h96;

  function automatic logic [15:0] pack_lvl(rdp_lvl_e l);
    logic [7:0] k;
    case (l)
      LVL_OPEN: k = OPEN_KEY;
      LVL_SEAL: k = SEAL_KEY;
      default:  k = GUARD_KEY;
    endcase
    return {~k, k};
  endfunction
endpackage

// File: rtl/rdp_decode.sv
module rdp_decode
  import rdp_pkg::*;
(
  input  logic [15:0] word_i,
  output rdp_lvl_e    lvl_o
);
  logic [7:0] key, chk;
  assign key = word_i[7:0];
  assign chk = word_i[15:8];

  always_comb begin
    if (chk != ~key)           lvl_o = LVL_GUARD;
    else if (key == OPEN_KEY)  lvl_o = LVL_OPEN;
    else if (key == SEAL_KEY)  lvl_o = LVL_SEAL;
    else                       lvl_o = LVL_GUARD;
  end
endmodule

// File: rtl/rdp_lock.sv
module rdp_lock
  import rdp_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  rdp_lvl_e lvl_i,
  input  logic     dbg_acc_i,
  input  logic     dbg_sys_i,
  input  logic     dbg_gnt_i,
  input  logic     clr_i,
  output logic     lock_o
);
  logic lock_q, arm;

  // only system-bus traffic arms; internal register accesses do not
  assign arm    = (lvl_i == LVL_GUARD) && ((dbg_acc_i && dbg_sys_i) || dbg_gnt_i);
  assign lock_o = lock_q || arm;

  // cleared by power-on reset or completed erase only
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    lock_q <= 1'b0;
    else if (clr_i) lock_q <= 1'b0;
    else if (arm)   lock_q <= 1'b1;
  end
endmodule

// File: rtl/rdp_read_gate.sv
module rdp_read_gate
  import rdp_pkg::*;
#(
  parameter int NSRC    = N_SRC,
  parameter int DBG_IDX = SRC_DBG,
  parameter int DATA_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              warm_rst_i,
  input  logic [NSRC-1:0]   req_i,
  input  rdp_lvl_e          lvl_i,
  input  logic              lock_i,
  input  logic [DATA_W-1:0] flash_rdata_i,
  output logic [NSRC-1:0]   gnt_o,
  output logic [NSRC-1:0]   rvalid_o,
  output logic [NSRC-1:0]   err_o,
  output logic              flash_rd_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic [NSRC-1:0] blk, rv_q, re_q;

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    if (i == 0) begin : g_top
      assign gnt_o[i] = req_i[i];
    end else begin : g_low
      assign gnt_o[i] = req_i[i] && !(|req_i[i-1:0]);
    end
    if (i == DBG_IDX) begin : g_dbg
      assign blk[i] = (lvl_i == LVL_SEAL) || (lvl_i == LVL_GUARD && lock_i);
    end else begin : g_sys
      assign blk[i] = (lvl_i == LVL_GUARD) && lock_i;
    end
  end

  assign flash_rd_o = |(gnt_o & ~blk);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rv_q <= '0;
      re_q <= '0;
    end else if (warm_rst_i) begin
      rv_q <= '0;
      re_q <= '0;
    end else begin
      rv_q <= gnt_o & ~blk;
      re_q <= gnt_o & blk;
    end
  end

  assign rvalid_o = rv_q;
  assign err_o    = re_q;
  assign rdata_o  = (|rv_q) ? flash_rdata_i : '0;
endmodule

// File: rtl/rdp_level_ctrl.sv
module rdp_level_ctrl
  import rdp_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        warm_rst_i,
  input  logic        opt_load_i,
  input  logic [15:0] opt_word_i,
  input  rdp_lvl_e    lvl_i,
  input  logic        chg_req_i,
  input  logic [1:0]  chg_tgt_i,
  input  logic        erase_done_i,
  output logic [15:0] word_o,
  output logic        erase_req_o,
  output logic        ack_o,
  output logic        rej_o,
  output logic        clr_lock_o
);
  logic [15:0] word_q;
  logic        erase_q, ack_q, rej_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q  <= pack_lvl(LVL_GUARD);
      erase_q <= 1'b0;
      ack_q   <= 1'b0;
      rej_q   <= 1'b0;
    end else begin
      ack_q <= 1'b0;
      rej_q <= 1'b0;
      if (warm_rst_i) begin
        erase_q <= 1'b0;
      end else if (opt_load_i) begin
        word_q  <= opt_word_i;
        erase_q <= 1'b0;
      end else if (erase_q) begin
        if (erase_done_i) begin
          word_q  <= pack_lvl(LVL_OPEN);
          erase_q <= 1'b0;
          ack_q   <= 1'b1;
        end
        if (chg_req_i) rej_q <= 1'b1;
      end else if (chg_req_i) begin
        if (chg_tgt_i == 2'd3) begin
          rej_q <= 1'b1;
        end else if (chg_tgt_i == lvl_i) begin
          ack_q <= 1'b1;
        end else if (chg_tgt_i > lvl_i) begin
          word_q <= pack_lvl(rdp_lvl_e'(chg_tgt_i));
          ack_q  <= 1'b1;
        end else if (lvl_i == LVL_SEAL) begin
          rej_q <= 1'b1;
        end else begin
          erase_q <= 1'b1;
        end
      end
    end
  end

  assign word_o      = word_q;
  assign erase_req_o = erase_q;
  assign ack_o       = ack_q;
  assign rej_o       = rej_q;
  assign clr_lock_o  = erase_q && erase_done_i && !warm_rst_i && !opt_load_i;
endmodule

// File: rtl/flash_rdp_ctrl.sv
module flash_rdp_ctrl
  import rdp_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              warm_rst_i,
  input  logic              opt_load_i,
  input  logic [15:0]       opt_word_i,
  input  logic              cpu_req_i,
  output logic              cpu_gnt_o,
  output logic              cpu_rvalid_o,
  output logic              cpu_err_o,
  input  logic              dma_req_i,
  output logic              dma_gnt_o,
  output logic              dma_rvalid_o,
  output logic              dma_err_o,
  input  logic              dbg_req_i,
  output logic              dbg_gnt_o,
  output logic              dbg_rvalid_o,
  output logic              dbg_err_o,
  input  logic              dbg_acc_i,
  input  logic              dbg_sys_i,
  output logic              flash_rd_o,
  input  logic [DATA_W-1:0] flash_rdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              chg_req_i,
  input  logic [1:0]        chg_tgt_i,
  output logic              chg_ack_o,
  output logic              chg_rej_o,
  output logic              erase_req_o,
  input  logic              erase_done_i,
  output logic [1:0]        level_o,
  output logic              lock_o
);
  logic [15:0]      word;
  rdp_lvl_e         lvl;
  logic             clr_lock, lock;
  logic [N_SRC-1:0] req, gnt, rvalid, err;

  assign req[SRC_CPU] = cpu_req_i;
  assign req[SRC_DMA] = dma_req_i;
  assign req[SRC_DBG] = dbg_req_i;

  rdp_level_ctrl u_ctrl (
    .clk_i, .rst_ni, .warm_rst_i, .opt_load_i, .opt_word_i,
    .lvl_i(lvl), .chg_req_i, .chg_tgt_i, .erase_done_i,
    .word_o(word), .erase_req_o, .ack_o(chg_ack_o), .rej_o(chg_rej_o),
    .clr_lock_o(clr_lock)
  );

  rdp_decode u_dec (.word_i(word), .lvl_o(lvl));

  rdp_lock u_lock (
    .clk_i, .rst_ni, .lvl_i(lvl), .dbg_acc_i, .dbg_sys_i,
    .dbg_gnt_i(gnt[SRC_DBG]), .clr_i(clr_lock), .lock_o(lock)
  );

  rdp_read_gate #(.NSRC(N_SRC), .DBG_IDX(SRC_DBG), .DATA_W(DATA_W)) u_gate (
    .clk_i, .rst_ni, .warm_rst_i, .req_i(req), .lvl_i(lvl), .lock_i(lock),
    .flash_rdata_i, .gnt_o(gnt), .rvalid_o(rvalid), .err_o(err),
    .flash_rd_o, .rdata_o
  );

  assign cpu_gnt_o    = gnt[SRC_CPU];
  assign dma_gnt_o    = gnt[SRC_DMA];
  assign dbg_gnt_o    = gnt[SRC_DBG];
  assign cpu_rvalid_o = rvalid[SRC_CPU];
  assign dma_rvalid_o = rvalid[SRC_DMA];
  assign dbg_rvalid_o = rvalid[SRC_DBG];
  assign cpu_err_o    = err[SRC_CPU];
  assign dma_err_o    = err[SRC_DMA];
  assign dbg_err_o    = err[SRC_DBG];
  assign level_o      = lvl;
  assign lock_o       = lock;
endmodule

// File: rtl/rdp_ctrl_chk.sv
module rdp_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       warm_rst_i,
  input logic       opt_load_i,
  input logic       cpu_req_i,
  input logic       dma_req_i,
  input logic       cpu_gnt_o,
  input logic       dma_gnt_o,
  input logic       dbg_gnt_o,
  input logic       dbg_err_o,
  input logic       flash_rd_o,
  input logic       erase_req_o,
  input logic       erase_done_i,
  input logic [1:0] level_o,
  input logic       lock_o
);
  // R2
  one_grant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({cpu_gnt_o, dma_gnt_o, dbg_gnt_o}));

  // R2
  dbg_last_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dbg_gnt_o |-> !(cpu_req_i || dma_req_i));

  // R4
  locked_no_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_o && level_o == 2'd1) |-> !flash_rd_o);

  // R7
  seal_dbg_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dbg_gnt_o && level_o == 2'd2 && !warm_rst_i) |=> dbg_err_o);

  // R8
  lock_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_o && !erase_done_i) |=> lock_o);

  // R10
  erase_guard_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    erase_req_o |-> level_o == 2'd1);

  // R11
  seal_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (level_o == 2'd2 && !opt_load_i) |=> level_o == 2'd2);
endmodule

bind flash_rdp_ctrl rdp_ctrl_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .warm_rst_i(warm_rst_i), .opt_load_i(opt_load_i),
  .cpu_req_i(cpu_req_i), .dma_req_i(dma_req_i), .cpu_gnt_o(cpu_gnt_o),
  .dma_gnt_o(dma_gnt_o), .dbg_gnt_o(dbg_gnt_o), .dbg_err_o(dbg_err_o),
  .flash_rd_o(flash_rd_o), .erase_req_o(erase_req_o), .erase_done_i(erase_done_i),
  .level_o(level_o), .lock_o(lock_o)
);

// File: tb/sim_flash_rdp_ctrl.sv
module sim_flash_rdp_ctrl;
  localparam int PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        warm_rst_i = 1'b0, opt_load_i = 1'b0;
  logic [15:0] opt_word_i = '0;
  logic        cpu_req_i = 1'b0, dma_req_i = 1'b0, dbg_req_i = 1'b0;
  logic        dbg_acc_i = 1'b0, dbg_sys_i = 1'b0;
  logic        cpu_gnt_o, cpu_rvalid_o, cpu_err_o;
  logic        dma_gnt_o, dma_rvalid_o, dma_err_o;
  logic        dbg_gnt_o, dbg_rvalid_o, dbg_err_o;
  logic        flash_rd_o;
  logic [31:0] flash_rdata_i = '0, rdata_o;
  logic        chg_req_i = 1'b0;
  logic [1:0]  chg_tgt_i = '0;
  logic        chg_ack_o, chg_rej_o, erase_req_o;
  logic        erase_done_i = 1'b0;
  logic [1:0]  level_o;
  logic        lock_o;

  always #(PERIOD/2) clk_i = ~clk_i;

  flash_rdp_ctrl u0 (.*);

  int    vectors = 0, miscompares = 0;
  bit    done = 0;
  string ph = "R1";

  // reference state
  int m_lvl;
  bit m_lock, m_erase, m_ack, m_rej;
  bit m_rv[3], m_re[3];

  function automatic int dec(logic [15:0] w);
    if (w[15:8] !== ~w[7:0]) return 1;
    if (w[7:0] == 8'hAA) return 0;
    if (w[7:0] == 8'hCC) return 2;
    return 1;
  endfunction

  function automatic int pick();
    if (cpu_req_i) return 0;
    if (dma_req_i) return 1;
    if (dbg_req_i) return 2;
    return -1;
  endfunction

  function automatic bit arming();
    return m_lvl == 1 && ((dbg_acc_i && dbg_sys_i) || pick() == 2);
  endfunction

  function automatic bit blocked(int src);
    bit lk;
    lk = m_lock || arming();
    return (m_lvl == 1 && lk) || (src == 2 && m_lvl == 2);
  endfunction

  bit bad;
  task automatic cmp(string nm, logic [31:0] act, logic [31:0] exp);
    if (act !== exp) begin
      bad = 1;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", ph, nm, act, exp, $time);
    end
  endtask

  task automatic check();
    int g;
    bit any;
    g = pick();
    bad = 0;
    any = m_rv[0] || m_rv[1] || m_rv[2];
    cmp("level_o", 32'(level_o), 32'(m_lvl));
    cmp("lock_o", 32'(lock_o), 32'(m_lock || arming()));
    cmp("cpu_gnt_o", 32'(cpu_gnt_o), 32'(g == 0));
    cmp("dma_gnt_o", 32'(dma_gnt_o), 32'(g == 1));
    cmp("dbg_gnt_o", 32'(dbg_gnt_o), 32'(g == 2));
    cmp("flash_rd_o", 32'(flash_rd_o), 32'(g >= 0 && !blocked(g)));
    cmp("cpu_rvalid_o", 32'(cpu_rvalid_o), 32'(m_rv[0]));
    cmp("dma_rvalid_o", 32'(dma_rvalid_o), 32'(m_rv[1]));
    cmp("dbg_rvalid_o", 32'(dbg_rvalid_o), 32'(m_rv[2]));
    cmp("cpu_err_o", 32'(cpu_err_o), 32'(m_re[0]));
    cmp("dma_err_o", 32'(dma_err_o), 32'(m_re[1]));
    cmp("dbg_err_o", 32'(dbg_err_o), 32'(m_re[2]));
    cmp("rdata_o", rdata_o, any ? flash_rdata_i : 32'h0);
    cmp("chg_ack_o", 32'(chg_ack_o), 32'(m_ack));
    cmp("chg_rej_o", 32'(chg_rej_o), 32'(m_rej));
    cmp("erase_req_o", 32'(erase_req_o), 32'(m_erase));
    vectors++;
    if (bad) miscompares++;
  endtask

  task automatic update();
    int g, tgt;
    bit arm, clr, nack, nrej;
    g = pick();
    arm = arming();
    clr = m_erase && erase_done_i && !warm_rst_i && !opt_load_i;
    for (int i = 0; i < 3; i++) begin
      bit b;
      b = blocked(i);
      m_rv[i] = !warm_rst_i && g == i && !b;
      m_re[i] = !warm_rst_i && g == i && b;
    end
    nack = 0; nrej = 0;
    tgt = int'(chg_tgt_i);
    if (warm_rst_i) m_erase = 0;
    else if (opt_load_i) begin m_lvl = dec(opt_word_i); m_erase = 0; end
    else if (m_erase) begin
      if (erase_done_i) begin m_lvl = 0; m_erase = 0; nack = 1; end
      if (chg_req_i) nrej = 1;
    end else if (chg_req_i) begin
      if (tgt == 3) nrej = 1;
      else if (tgt == m_lvl) nack = 1;
      else if (tgt > m_lvl) begin m_lvl = tgt; nack = 1; end
      else if (m_lvl == 2) nrej = 1;
      else m_erase = 1;
    end
    if (clr) m_lock = 0;
    else if (arm) m_lock = 1;
    m_ack = nack; m_rej = nrej;
  endtask

  task automatic step();
    #1 check();
    @(posedge clk_i);
    update();
    @(negedge clk_i);
  endtask

  task automatic quiet();
    cpu_req_i = 0; dma_req_i = 0; dbg_req_i = 0; dbg_acc_i = 0; dbg_sys_i = 0;
    chg_req_i = 0; opt_load_i = 0; warm_rst_i = 0; erase_done_i = 0;
  endtask

  task automatic por();
    quiet();
    rst_ni = 0;
    m_lvl = 1; m_lock = 0; m_erase = 0; m_ack = 0; m_rej = 0;
    for (int i = 0; i < 3; i++) begin m_rv[i] = 0; m_re[i] = 0; end
    @(negedge clk_i); @(negedge clk_i);
    rst_ni = 1;
  endtask

  task automatic load(logic [15:0] w);
    opt_word_i = w; opt_load_i = 1; step(); opt_load_i = 0; step();
  endtask

  task automatic reads(bit c, bit d, bit g);
    cpu_req_i = c; dma_req_i = d; dbg_req_i = g;
    flash_rdata_i = $urandom;
    step();
  endtask

  task automatic change(logic [1:0] t);
    chg_tgt_i = t; chg_req_i = 1; step(); chg_req_i = 0; step();
  endtask

  task automatic mix(int n, bit with_dbg_acc);
    for (int k = 0; k < n; k++) begin
      dbg_acc_i = with_dbg_acc && ($urandom_range(0, 7) == 0);
      dbg_sys_i = $urandom_range(0, 1) == 1;
      reads($urandom_range(0, 3) == 0, $urandom_range(0, 2) == 0, $urandom_range(0, 1) == 1);
    end
    quiet();
    step();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  initial begin
    #(PERIOD * 100000);
    $display("FAIL watchdog expired t=%0t", $time);
    miscompares++;
    finish_run();
  end

  initial begin
    @(negedge clk_i);
    // R1: reset state and decode
    por();
    step(); step();
    load(16'h55AA);
    load(16'h33CC);
    load(16'h33CD);
    load(16'h54AA);
    load(16'hFFFF);
    load(16'h55AA);

    // R2 / R3: arbitration and responses at level 0
    ph = "R2";
    reads(1, 1, 1); reads(1, 0, 1); reads(0, 1, 1); reads(0, 0, 1);
    reads(1, 1, 0); reads(0, 0, 0);
    ph = "R3";
    reads(0, 1, 0); reads(0, 0, 0); reads(1, 0, 0); reads(0, 0, 0);
    // R6: debug bus activity at level 0 does not lock
    ph = "R6";
    dbg_acc_i = 1; dbg_sys_i = 1;
    reads(0, 0, 1); reads(0, 0, 1); reads(1, 0, 0);
    quiet(); step();
    mix(60, 1);

    // R9: raise 0 -> 1 -> 2, same-level request
    ph = "R9";
    change(2'd1);
    change(2'd1);
    change(2'd2);

    // R7: level 2 behaviour
    ph = "R7";
    dbg_acc_i = 1; dbg_sys_i = 1;
    reads(0, 0, 1); reads(1, 0, 0); reads(0, 1, 1); reads(0, 0, 1);
    quiet(); step();

    // R11: refusals at level 2
    ph = "R11";
    change(2'd0); change(2'd1); change(2'd3); change(2'd2);

    // R5: internal register accesses at level 1
    ph = "R5";
    por(); step();
    load(16'h1234);
    dbg_acc_i = 1; dbg_sys_i = 0;
    reads(1, 0, 0); reads(0, 1, 0); reads(0, 0, 0); reads(1, 1, 0);
    quiet(); step();

    // R4: debug read held off by CPU, then wins and arms the lock
    ph = "R4";
    reads(1, 0, 1); reads(1, 0, 1); reads(1, 1, 1);
    reads(0, 0, 1);
    reads(1, 0, 0); reads(0, 1, 0); reads(0, 0, 1); reads(0, 0, 0);

    // R8: warm reset keeps the lock
    ph = "R8";
    warm_rst_i = 1; reads(1, 0, 0); reads(0, 0, 0);
    warm_rst_i = 0; reads(1, 0, 0); reads(0, 0, 0);

    // R10: erase path with refused requests while pending
    ph = "R10";
    chg_tgt_i = 2'd0; chg_req_i = 1; step(); chg_req_i = 0;
    reads(1, 0, 0); reads(0, 0, 0);
    ph = "R11";
    change(2'd2);
    ph = "R10";
    step(); step();
    erase_done_i = 1; step(); erase_done_i = 0;
    reads(1, 0, 0); reads(0, 0, 1); reads(0, 0, 0);

    // R8: warm reset cancels a pending erase
    ph = "R8";
    change(2'd1);
    dbg_acc_i = 1; dbg_sys_i = 1; step(); dbg_acc_i = 0;
    chg_tgt_i = 2'd0; chg_req_i = 1; step(); chg_req_i = 0;
    step();
    warm_rst_i = 1; step(); warm_rst_i = 0;
    erase_done_i = 1; step(); erase_done_i = 0;
    reads(1, 0, 0); reads(0, 0, 0);

    // R4 / R9: random traffic at level 1 then raise while locked
    ph = "R4";
    por(); step();
    load(16'h0000);
    mix(80, 1);
    ph = "R9";
    change(2'd2);
    reads(1, 0, 0); reads(0, 0, 0);

    finish_run();
  end
endmodule